// File: doc/BRIEF.md
# Split-Half Cycle and Retire Counters

This block holds two 64-bit event counters inside a processor's control-register space. One counts clock cycles and advances on every clock once reset is released. The other counts completed instructions and advances on each cycle in which the pipeline raises its retire pulse. Software sees each counter as two 32-bit registers, a low half and an upper half. It can read or overwrite either half through a single-cycle register port.

The control-register port is one-cycle and combinational on the read side. In a cycle with `csr_valid_i` high, the block decodes `csr_addr_i` and returns the addressed half on `csr_rdata_o`. If `csr_we_i` is also high, the block loads `csr_wdata_i` into that half at the next clock edge. An access to an address the block does not own raises `csr_miss_o` so that the surrounding register file can route or fault it. The two counters are built as identical split-counter instances. A decode state (`SEL_NONE`, `SEL_CYC_LO`, `SEL_CYC_HI`, `SEL_RET_LO`, `SEL_RET_HI`) is recomputed every cycle from the address and chooses the read source and the write target.

Top module: `perf_ctr_top`

## Requirements
- R1: After reset, all four halves read as zero.
- R2: When no write targets its low half, the cycle counter's low half increases by one on every clock after reset.
- R3: The retire counter increases by one at each clock edge where `retire_i` was high. It holds its value at edges where `retire_i` was low and no write targeted it.
- R4: When a low half at 0xFFFFFFFF increments, it wraps to zero and its upper half increases by one at the same clock edge.
- R5: With `csr_valid_i` high, the address map is 0xB00 for cycle low, 0xB80 for cycle upper, 0xB02 for retire low and 0xB82 for retire upper. `csr_rdata_o` shows the addressed half as it stands in that cycle, before that cycle's update.
- R6: A write (`csr_valid_i` and `csr_we_i` high) loads `csr_wdata_i` into the addressed half at the next edge. It overrides that half's own increment, including a carry arriving into an upper half.
- R7: A write to one half leaves the other half on its normal behaviour. This includes the carry that the overwritten low half would have produced.
- R8: With `csr_valid_i` high and any other address, `csr_miss_o` is 1, `csr_rdata_o` is 0, and no counter state is altered. With `csr_valid_i` low, `csr_miss_o` is 0, `csr_rdata_o` is 0 and no write happens.
- R9: A read (`csr_we_i` low) alters no counter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One pulse per completed instruction |
| csr_valid_i | input | 1 | Register access in this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, zero unless a valid hit |
| csr_miss_o | output | 1 | Valid access to an address not owned here |

## Verification
The bench steers the low halves to 0xFFFFFFFE and 0xFFFFFFFF so that wraps occur on known edges. A design that dropped the carry would leave the upper half stuck. A design that delayed the carry would show it one cycle late.

The bench also writes the low half in the very cycle it wraps. A design that let the overwrite swallow the carry would lose a count in the upper half. It further writes the upper half while a carry arrives, where a design giving the carry priority would read back one above the written value.

Off-map and invalid writes are followed by readbacks of all four halves. These expose a decoder that matches on partial address bits, or that ignores the valid qualifier.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

    localparam int unsigned HALF_W = 32;
    localparam int unsigned ADDR_W = 12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI
    } csr_sel_e;

endpackage

// File: rtl/perf_ctr_decode.sv
module perf_ctr_decode
    import perf_ctr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter logic [AW-1:0] A_CYC_LO = 12'hB00,
    parameter logic [AW-1:0] A_CYC_HI = 12'hB80,
    parameter logic [AW-1:0] A_RET_LO = 12'hB02,
    parameter logic [AW-1:0] A_RET_HI = 12'hB82
) (
    input  logic          valid_i,
    input  logic [AW-1:0] addr_i,
    output csr_sel_e      sel_o,
    output logic          miss_o
);

    // Decode state: recomputed every cycle from the address.
    always_comb begin
        sel_o = SEL_NONE;
        if (valid_i) begin
            if (addr_i == A_CYC_LO)      sel_o = SEL_CYC_LO;
            else if (addr_i == A_CYC_HI) sel_o = SEL_CYC_HI;
            else if (addr_i == A_RET_LO) sel_o = SEL_RET_LO;
            else if (addr_i == A_RET_HI) sel_o = SEL_RET_HI;
        end
    end

    assign miss_o = valid_i && (sel_o == SEL_NONE);

endmodule

// File: rtl/perf_ctr_split.sv
module perf_ctr_split #(
    parameter int unsigned HW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          inc_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [HW-1:0] wdata_i,
    output logic [HW-1:0] lo_o,
    output logic [HW-1:0] hi_o
);

    logic [HW-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [HW:0]   lo_sum;
    logic          carry;

    // Next-state: increment with carry, then let a write override its half.
    always_comb begin
        lo_sum = {1'b0, lo_q} + (HW+1)'(inc_i);
        carry  = lo_sum[HW];
        lo_d   = wr_lo_i ? wdata_i : lo_sum[HW-1:0];
        hi_d   = wr_hi_i ? wdata_i : hi_q + HW'(carry);
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

endmodule

// File: rtl/perf_ctr_top.sv
module perf_ctr_top
    import perf_ctr_pkg::*;
#(
    parameter int unsigned HW = HALF_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          retire_i,
    input  logic          csr_valid_i,
    input  logic          csr_we_i,
    input  logic [AW-1:0] csr_addr_i,
    input  logic [HW-1:0] csr_wdata_i,
    output logic [HW-1:0] csr_rdata_o,
    output logic          csr_miss_o
);

    localparam int unsigned NUM_CTR = 2;   // 0: cycles, 1: retired

    csr_sel_e             sel;
    logic [NUM_CTR-1:0]   inc, wr_lo, wr_hi;
    logic [HW-1:0]        lo_q [NUM_CTR];
    logic [HW-1:0]        hi_q [NUM_CTR];
    logic [2*HW-1:0]      cyc_val, ret_val;

    perf_ctr_decode #(.AW(AW)) u_dec (
        .valid_i (csr_valid_i),
        .addr_i  (csr_addr_i),
        .sel_o   (sel),
        .miss_o  (csr_miss_o)
    );

    assign inc = {retire_i, 1'b1};

    // Output process: read source and write target per decode state.
    always_comb begin
        wr_lo       = '0;
        wr_hi       = '0;
        csr_rdata_o = '0;
        unique case (sel)
            SEL_CYC_LO: begin wr_lo[0] = csr_we_i; csr_rdata_o = lo_q[0]; end
            SEL_CYC_HI: begin wr_hi[0] = csr_we_i; csr_rdata_o = hi_q[0]; end
            SEL_RET_LO: begin wr_lo[1] = csr_we_i; csr_rdata_o = lo_q[1]; end
            SEL_RET_HI: begin wr_hi[1] = csr_we_i; csr_rdata_o = hi_q[1]; end
            SEL_NONE:   ;
            default:    ;
        endcase
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        perf_ctr_split #(.HW(HW)) u_ctr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .inc_i   (inc[g]),
            .wr_lo_i (wr_lo[g]),
            .wr_hi_i (wr_hi[g]),
            .wdata_i (csr_wdata_i),
            .lo_o    (lo_q[g]),
            .hi_o    (hi_q[g])
        );
    end

    assign cyc_val = {hi_q[0], lo_q[0]};
    assign ret_val = {hi_q[1], lo_q[1]};

endmodule

// File: rtl/perf_ctr_checker.sv
module perf_ctr_checker #(
    parameter int unsigned HW = 32,
    parameter int unsigned AW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          retire_i,
    input logic          csr_valid_i,
    input logic          csr_we_i,
    input logic [AW-1:0] csr_addr_i,
    input logic [HW-1:0] csr_wdata_i,
    input logic [HW-1:0] csr_rdata_o,
    input logic          csr_miss_o,
    input logic [2*HW-1:0] cyc_val,
    input logic [2*HW-1:0] ret_val
);

    logic armed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;
    end

    logic w_cl, w_ch, w_rl, w_rh;
    assign w_cl = csr_valid_i && csr_we_i && (csr_addr_i == 12'hB00);
    assign w_ch = csr_valid_i && csr_we_i && (csr_addr_i == 12'hB80);
    assign w_rl = csr_valid_i && csr_we_i && (csr_addr_i == 12'hB02);
    assign w_rh = csr_valid_i && csr_we_i && (csr_addr_i == 12'hB82);

    AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        !$past(w_cl) |-> cyc_val[HW-1:0] == $past(cyc_val[HW-1:0]) + 1'b1); // R2

    AST_CYC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (!$past(w_cl) && !$past(w_ch) && $past(cyc_val[HW-1:0]) == {HW{1'b1}})
        |-> cyc_val[2*HW-1:HW] == $past(cyc_val[2*HW-1:HW]) + 1'b1); // R4

    AST_RET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (!$past(retire_i) && !$past(w_rl) && !$past(w_rh)) |-> $stable(ret_val)); // R3

    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        $past(w_cl) |-> cyc_val[HW-1:0] == $past(csr_wdata_i)); // R6

    AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_miss_o |-> csr_rdata_o == '0); // R8

    AST_MISS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_valid_i |-> !csr_miss_o); // R8

endmodule

bind perf_ctr_top perf_ctr_checker #(.HW(HW), .AW(AW)) u_chk (.*);

// File: tb/perf_ctr_top_test.sv
`timescale 1ns/1ps
module perf_ctr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic        valid = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        miss;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Reference state
    logic [63:0] m_cyc = '0;
    logic [63:0] m_ret = '0;

    always #2 clk = ~clk;   // 250 MHz

    perf_ctr_top uut (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire),
        .csr_valid_i(valid), .csr_we_i(we), .csr_addr_i(addr),
        .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_miss_o(miss)
    );

    function automatic logic [31:0] exp_read(logic v, logic [11:0] a);
        if (!v) return 32'h0;
        case (a)
            12'hB00: return m_cyc[31:0];
            12'hB80: return m_cyc[63:32];
            12'hB02: return m_ret[31:0];
            12'hB82: return m_ret[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_miss(logic v, logic [11:0] a);
        return v && !(a == 12'hB00 || a == 12'hB80 || a == 12'hB02 || a == 12'hB82);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive, compare, advance the model.
    task automatic step(logic v, logic w, logic [11:0] a, logic [31:0] d,
                        logic r, string tag);
        logic [63:0] nc, nr;
        valid = v; we = w; addr = a; wdata = d; retire = r;
        #1;
        check({tag, " rdata"}, rdata, exp_read(v, a));
        check({tag, " miss"}, {31'b0, miss}, {31'b0, exp_miss(v, a)});
        @(posedge clk);
        nc = m_cyc + 64'd1;
        nr = m_ret + (r ? 64'd1 : 64'd0);
        if (v && w) begin
            case (a)
                12'hB00: nc[31:0]  = d;
                12'hB80: nc[63:32] = d;
                12'hB02: nr[31:0]  = d;
                12'hB82: nr[63:32] = d;
                default: ;
            endcase
        end
        m_cyc = nc;
        m_ret = nr;
        @(negedge clk);
    endtask

    task automatic read_all(string tag);
        step(1, 0, 12'hB00, 32'h0, 0, tag);
        step(1, 0, 12'hB80, 32'h0, 0, tag);
        step(1, 0, 12'hB02, 32'h0, 0, tag);
        step(1, 0, 12'hB82, 32'h0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        valid = 1; addr = 12'hB00; #1;
        check("R1 reset cycle low", rdata, 32'h0);
        addr = 12'hB82; #1;
        check("R1 reset retire upper", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1;

        read_all("R1 R5 R9 readback");
        read_all("R2 R9 second pass");

        // R3: retire pattern
        step(1, 0, 12'hB02, 0, 1, "R3 pulse");
        step(1, 0, 12'hB02, 0, 0, "R3 idle");
        step(1, 0, 12'hB02, 0, 1, "R3 pulse");
        step(1, 0, 12'hB02, 0, 1, "R3 pulse");
        step(1, 0, 12'hB02, 0, 0, "R3 observe");

        // R6 then R4: cycle low wraps into upper
        step(1, 1, 12'hB00, 32'hFFFF_FFFE, 0, "R6 write cycle low");
        step(1, 0, 12'hB00, 0, 0, "R6 readback");
        step(1, 0, 12'hB00, 0, 0, "R4 pre-wrap");
        step(1, 0, 12'hB80, 0, 0, "R4 carry upper");
        step(1, 0, 12'hB00, 0, 0, "R4 wrapped low");

        // R7: overwrite low in its wrap cycle, carry still lands
        step(1, 1, 12'hB00, 32'hFFFF_FFFF, 0, "R7 load all-ones");
        step(1, 1, 12'hB00, 32'h0000_0005, 0, "R7 write at wrap");
        step(1, 0, 12'hB80, 0, 0, "R7 upper kept carry");
        step(1, 0, 12'hB00, 0, 0, "R7 low written");

        // R6: upper write beats incoming carry
        step(1, 1, 12'hB00, 32'hFFFF_FFFF, 0, "R6 load all-ones");
        step(1, 1, 12'hB80, 32'h0000_ABCD, 0, "R6 upper at carry");
        step(1, 0, 12'hB80, 0, 0, "R6 upper wins");
        step(1, 0, 12'hB00, 0, 0, "R6 low wrapped");

        // Retire counter wrap and write interactions
        step(1, 1, 12'hB02, 32'hFFFF_FFFF, 0, "R6 retire low");
        step(1, 0, 12'hB82, 0, 1, "R4 retire carry");
        step(1, 0, 12'hB82, 0, 0, "R4 retire upper");
        step(1, 1, 12'hB02, 32'hFFFF_FFFF, 0, "R6 retire reload");
        step(1, 1, 12'hB02, 32'h0000_0010, 1, "R7 retire low at wrap");
        step(1, 0, 12'hB82, 0, 0, "R7 retire upper carry");
        step(1, 1, 12'hB82, 32'h1234_5678, 1, "R7 retire upper write");
        step(1, 0, 12'hB02, 0, 0, "R7 retire low counted");
        step(1, 0, 12'hB82, 0, 0, "R6 retire upper written");

        // R8: off-map writes and invalid write
        step(1, 1, 12'hB01, 32'hDEAD_BEEF, 0, "R8 miss B01");
        step(1, 1, 12'hB03, 32'hDEAD_BEEF, 1, "R8 miss B03");
        step(1, 1, 12'h300, 32'hDEAD_BEEF, 0, "R8 miss 300");
        step(1, 1, 12'hB81, 32'hDEAD_BEEF, 0, "R8 miss B81");
        step(0, 1, 12'hB00, 32'hDEAD_BEEF, 0, "R8 invalid write");
        step(0, 1, 12'hB82, 32'hDEAD_BEEF, 0, "R8 invalid write");
        read_all("R8 R9 state intact");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule